// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a tree of descriptors that lives in memory, up to three levels deep. A caller pulses `start` with the address and the kind of access, read or write. The walker then starts from a 64-bit root pointer. That pointer is presented as two 32-bit words: an attribute word and a table base word. The walker fetches one descriptor per level through a simple memory port that carries one word per request and waits for an acknowledge on each. When the walk ends, the block pulses `done` and reports one of two outcomes: a physical address with its write-protect and cache-inhibit attributes, or a fault code.

Each descriptor has a two-bit type in bits 1:0 of its attribute word. The type says whether the entry is invalid, maps a page, or points to a next table. A next table is either short-format (one word per entry) or long-format (two words per entry). A page descriptor may end the walk at any level, so larger pages are reached after one or two levels. The walker also keeps the descriptors' history bits up to date: it sets the used bit in each descriptor it visits and the modified bit in the final page on a write. It does this by rewriting only the attribute word, and only when a bit actually changes. The width of each level's index field is set by a build-time parameter.

Top module: `mmu_table_walker`

## Requirements
- R1: A root pointer whose type (root attribute bits 1:0) is 0 or 1 ends the request with fault code 1 (invalid) and makes no memory access. Type 3 makes the first-level table long-format, and type 2 makes it short-format.
- R2: When root attribute bit 31 is 0, a first-level index greater than root attribute bits 30:16 ends the request with fault code 3 (limit) and makes no memory access. An index equal to the limit proceeds. When bit 31 is 1, no limit test is made.
- R3: The entry address is the table base with bits 3:0 cleared, plus the index times 8 for a long-format table or times 4 for a short-format table. A long entry is read as two words: the attribute word at the entry address, then the base word at +4. A short entry is read as a single word.
- R4: A descriptor type of 2 or 3 points to a next table that is short-format or long-format, respectively, with the table base in bits 31:4 of the base word (long) or of the only word (short). Type 0 at any level, or a non-page type at the third level, ends the request with fault code 1.
- R5: A page descriptor (type 1) at the first or second level ends the walk early. The page offset is then every virtual-address bit below that level's index: 25 bits after level one and 19 bits after level two with the default parameters.
- R6: On success, fault is 0 and the physical address is the page base word with its offset bits replaced by the virtual-address offset. `pa_ci` reflects bit 6 of the page's attribute word.
- R7: The write-protect bits (bit 2) of the root and of every visited descriptor are ORed together. On a write access, a set bit ends the request with fault code 2 (protection) at that descriptor, and that descriptor is not written back. On a read access, the result reports `pa_wp` = 1. After any fault, `pa`, `pa_wp` and `pa_ci` are 0.
- R8: The walker writes the used bit (bit 3) into the attribute word of each visited descriptor whose used bit is clear. A descriptor whose bits are already up to date is not written.
- R9: On a successful write access, the modified bit (bit 4) of the final page descriptor is set in the same write that sets its used bit.
- R10: `busy` rises only in the cycle after an accepted `start`, a `start` seen while busy is ignored, and `done` is a one-cycle pulse that ends the request.
- R11: `mem_req` stays high, with a stable address, write enable and write data, until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a translation (accepted when idle) |
| va | input | 32 | Virtual address to translate |
| is_write | input | 1 | Access is a write |
| root_attr | input | 32 | Root pointer attribute word |
| root_base | input | 32 | Root pointer table base word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| pa | output | 32 | Physical address (0 on fault) |
| pa_wp | output | 1 | Write protection seen on the path |
| pa_ci | output | 1 | Page is cache-inhibited |
| fault | output | 2 | 0 none, 1 invalid, 2 protection, 3 limit |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the walker with its default index widths of 7, 6 and 6 bits, which leaves a 13-bit page offset. With these widths, an early page after level one takes 25 offset bits and one after level two takes 19. The bench places short and long tables at hand-picked bases in a 16 KB memory model, so that every mix of entry formats and both early-termination depths is reached. The same page descriptor is also reached twice from different paths, which shows that history bits already set suppress the write-back.

// File: rtl/mmu_tw_pkg.sv
// Shared types for the page table walker.
// Assumes descriptor flag positions are fixed across all entry formats.
package mmu_tw_pkg;

    typedef enum logic [1:0] {
        KIND_INVALID = 2'd0,
        KIND_PAGE    = 2'd1,
        KIND_SHORT   = 2'd2,
        KIND_LONG    = 2'd3
    } desc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PROT    = 2'd2,
        FLT_LIMIT   = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ATTR,
        ST_RD_BASE,
        ST_WB,
        ST_ADV,
        ST_FIN
    } walk_state_e;

    typedef struct packed {
        desc_kind_e kind;
        logic       wp;
        logic       used;
        logic       modified;
        logic       ci;
    } desc_flags_t;

    localparam int unsigned POS_WP   = 2;
    localparam int unsigned POS_USED = 3;
    localparam int unsigned POS_MOD  = 4;
    localparam int unsigned POS_CI   = 6;

endpackage

// File: rtl/mmu_tw_desc_dec.sv
// Splits a descriptor attribute word into its type and flag bits.
// Assumes the same flag positions for long and short formats.
module mmu_tw_desc_dec
    import mmu_tw_pkg::*;
(
    input  logic [31:0]  attr,
    output desc_flags_t  flags
);
    logic attr_unused;

    // Field extraction
    always_comb begin
        flags.kind     = desc_kind_e'(attr[1:0]);
        flags.wp       = attr[POS_WP];
        flags.used     = attr[POS_USED];
        flags.modified = attr[POS_MOD];
        flags.ci       = attr[POS_CI];
    end

    assign attr_unused = ^{attr[31:7], attr[5]};
endmodule

// File: rtl/mmu_tw_index.sv
// Picks the index field for the current level, forms the entry address
// and gives the page-offset mask that applies if a page ends the walk there.
// Assumes level is 0..2 and the offset width is at least 8 bits.
module mmu_tw_index #(
    parameter int unsigned L1_W = 7,
    parameter int unsigned L2_W = 6,
    parameter int unsigned L3_W = 6
) (
    input  logic [31:0] va,
    input  logic [1:0]  level,
    input  logic [31:0] tbl_base,
    input  logic        is_long,
    output logic [31:0] entry_addr,
    output logic [31:0] off_mask
);
    localparam int unsigned OFF_W = 32 - L1_W - L2_W - L3_W;
    localparam logic [31:0] MASK_L1 = (32'd1 << (L2_W + L3_W + OFF_W)) - 32'd1;
    localparam logic [31:0] MASK_L2 = (32'd1 << (L3_W + OFF_W)) - 32'd1;
    localparam logic [31:0] MASK_L3 = (32'd1 << OFF_W) - 32'd1;

    logic [L1_W-1:0] idx1;
    logic [L2_W-1:0] idx2;
    logic [L3_W-1:0] idx3;
    logic [31:0]     idx_ext;
    logic            addr_unused;

    assign idx1 = va[31 -: L1_W];
    assign idx2 = va[OFF_W + L3_W +: L2_W];
    assign idx3 = va[OFF_W +: L3_W];

    // Level selection of index and offset mask
    always_comb begin
        case (level)
            2'd0:    begin idx_ext = 32'(idx1); off_mask = MASK_L1; end
            2'd1:    begin idx_ext = 32'(idx2); off_mask = MASK_L2; end
            default: begin idx_ext = 32'(idx3); off_mask = MASK_L3; end
        endcase
    end

    // Entry address: aligned base plus scaled index
    assign entry_addr = {tbl_base[31:4], 4'b0000}
                      + (is_long ? (idx_ext << 3) : (idx_ext << 2));

    assign addr_unused = ^{va[OFF_W-1:0], tbl_base[3:0]};
endmodule

// File: rtl/mmu_table_walker.sv
// Walks a descriptor tree of up to three levels for one request at a time.
// Checks the root pointer, fetches each descriptor (two words for long
// entries), updates the used/modified bits and reports an address or a fault.
// Assumes memory acknowledges each request exactly once, holding rdata with ack.
module mmu_table_walker
    import mmu_tw_pkg::*;
#(
    parameter int unsigned L1_IDX_W = 7,
    parameter int unsigned L2_IDX_W = 6,
    parameter int unsigned L3_IDX_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] va,
    input  logic        is_write,
    input  logic [31:0] root_attr,
    input  logic [31:0] root_base,
    output logic        busy,
    output logic        done,
    output logic [31:0] pa,
    output logic        pa_wp,
    output logic        pa_ci,
    output logic [1:0]  fault,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int unsigned LAST_LEVEL = 2;

    walk_state_e state_q;
    logic [31:0] va_q;
    logic        wr_q;
    logic [1:0]  level_q;
    logic [31:0] tbl_base_q;
    logic        long_q;
    logic        wp_acc_q;
    logic [31:0] attr_q;
    logic [31:0] base_q;
    logic [31:0] pa_q;
    logic        pa_wp_q;
    logic        pa_ci_q;
    fault_e      fault_q;

    desc_flags_t root_flags, rd_flags, cur_flags;
    logic [31:0] entry_addr, off_mask, page_word, new_attr;
    logic [L1_IDX_W-1:0] root_idx;
    logic        root_lim_fail, need_wb, cur_is_page;
    logic        flags_unused;

    mmu_tw_desc_dec u_dec_root (.attr(root_attr), .flags(root_flags));
    mmu_tw_desc_dec u_dec_rd   (.attr(mem_rdata), .flags(rd_flags));
    mmu_tw_desc_dec u_dec_cur  (.attr(attr_q),    .flags(cur_flags));

    mmu_tw_index #(.L1_W(L1_IDX_W), .L2_W(L2_IDX_W), .L3_W(L3_IDX_W)) u_index (
        .va(va_q), .level(level_q), .tbl_base(tbl_base_q), .is_long(long_q),
        .entry_addr(entry_addr), .off_mask(off_mask)
    );

    // Root upper-limit test on the incoming first-level index
    assign root_idx      = va[31 -: L1_IDX_W];
    assign root_lim_fail = !root_attr[31] && (32'(root_idx) > 32'(root_attr[30:16]));

    // Write-back value and whether a write is needed
    assign cur_is_page = (cur_flags.kind == KIND_PAGE);
    assign page_word   = long_q ? base_q : attr_q;
    always_comb begin
        new_attr = attr_q;
        new_attr[POS_USED] = 1'b1;
        if (cur_is_page && wr_q) new_attr[POS_MOD] = 1'b1;
    end
    assign need_wb = (new_attr != attr_q);

    // Memory port drive from state
    always_comb begin
        mem_req   = (state_q == ST_RD_ATTR) || (state_q == ST_RD_BASE)
                 || ((state_q == ST_WB) && need_wb);
        mem_we    = (state_q == ST_WB);
        mem_addr  = (state_q == ST_RD_BASE) ? entry_addr + 32'd4 : entry_addr;
        mem_wdata = new_attr;
    end

    // Walk sequencing and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            va_q       <= '0;
            wr_q       <= 1'b0;
            level_q    <= '0;
            tbl_base_q <= '0;
            long_q     <= 1'b0;
            wp_acc_q   <= 1'b0;
            attr_q     <= '0;
            base_q     <= '0;
            pa_q       <= '0;
            pa_wp_q    <= 1'b0;
            pa_ci_q    <= 1'b0;
            fault_q    <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    va_q       <= va;
                    wr_q       <= is_write;
                    level_q    <= '0;
                    tbl_base_q <= root_base;
                    long_q     <= (root_flags.kind == KIND_LONG);
                    wp_acc_q   <= root_flags.wp;
                    pa_q       <= '0;
                    pa_wp_q    <= 1'b0;
                    pa_ci_q    <= 1'b0;
                    fault_q    <= FLT_NONE;
                    if (root_flags.kind == KIND_INVALID || root_flags.kind == KIND_PAGE) begin
                        fault_q <= FLT_INVALID;
                        state_q <= ST_FIN;
                    end else if (root_lim_fail) begin
                        fault_q <= FLT_LIMIT;
                        state_q <= ST_FIN;
                    end else if (is_write && root_flags.wp) begin
                        fault_q <= FLT_PROT;
                        state_q <= ST_FIN;
                    end else begin
                        state_q <= ST_RD_ATTR;
                    end
                end
                ST_RD_ATTR: if (mem_ack) begin
                    attr_q <= mem_rdata;
                    if (rd_flags.kind == KIND_INVALID ||
                        (level_q == 2'(LAST_LEVEL) && rd_flags.kind != KIND_PAGE)) begin
                        fault_q <= FLT_INVALID;
                        state_q <= ST_FIN;
                    end else if (wr_q && (wp_acc_q || rd_flags.wp)) begin
                        fault_q <= FLT_PROT;
                        state_q <= ST_FIN;
                    end else begin
                        wp_acc_q <= wp_acc_q | rd_flags.wp;
                        state_q  <= long_q ? ST_RD_BASE : ST_WB;
                    end
                end
                ST_RD_BASE: if (mem_ack) begin
                    base_q  <= mem_rdata;
                    state_q <= ST_WB;
                end
                ST_WB: if (!need_wb || mem_ack) begin
                    state_q <= ST_ADV;
                end
                ST_ADV: begin
                    if (cur_is_page) begin
                        pa_q    <= (page_word & ~off_mask) | (va_q & off_mask);
                        pa_wp_q <= wp_acc_q;
                        pa_ci_q <= cur_flags.ci;
                        state_q <= ST_FIN;
                    end else begin
                        level_q    <= level_q + 2'd1;
                        tbl_base_q <= page_word;
                        long_q     <= (cur_flags.kind == KIND_LONG);
                        state_q    <= ST_RD_ATTR;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign done  = (state_q == ST_FIN);
    assign pa    = pa_q;
    assign pa_wp = pa_wp_q;
    assign pa_ci = pa_ci_q;
    assign fault = fault_q;

    assign flags_unused = ^{rd_flags.used, rd_flags.modified, rd_flags.ci,
                            root_flags.used, root_flags.modified, root_flags.ci,
                            cur_flags.wp, cur_flags.used, cur_flags.modified};
endmodule

// File: rtl/mmu_tw_chk.sv
// Protocol and sequencing properties for the table walker, bound to its top.
// Assumes a synchronous active-low reset.
module mmu_tw_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_wb_sets_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[3] && (mem_wdata[1:0] != 2'b00)));
endmodule

bind mmu_table_walker mmu_tw_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/mmu_table_walker_tb_top.sv
// Directed bench for the table walker with a one-cycle-latency memory model.
module mmu_table_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] va = '0;
    logic        is_write = 1'b0;
    logic [31:0] root_attr = 32'h8000_0003;
    logic [31:0] root_base = 32'h0;
    logic        busy, done, pa_wp, pa_ci, mem_req, mem_we;
    logic [31:0] pa, mem_addr, mem_wdata;
    logic [1:0]  fault;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:4095];
    int unsigned rd_cnt = 0, wr_cnt = 0;
    int unsigned n_chk = 0, n_err = 0;
    int unsigned cycles = 0;

    logic [31:0] r_pa;
    logic [1:0]  r_fault;
    logic        r_wp, r_ci;
    int unsigned d_rd, d_wr;

    mmu_table_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .va(va), .is_write(is_write),
        .root_attr(root_attr), .root_base(root_base), .busy(busy), .done(done),
        .pa(pa), .pa_wp(pa_wp), .pa_ci(pa_ci), .fault(fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2 clk = ~clk;

    // Memory model: acknowledge one cycle after each request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[13:2]];
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    // Global watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    function automatic logic [31:0] mkva(int unsigned i1, int unsigned i2,
                                         int unsigned i3, int unsigned off);
        return {7'(i1), 6'(i2), 6'(i3), 13'(off)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] data);
        mem[addr[13:2]] = data;
    endtask

    function automatic logic [31:0] peek(input logic [31:0] addr);
        return mem[addr[13:2]];
    endfunction

    // One request from start to done; records result and traffic
    task automatic run_walk(input logic [31:0] v, input logic wr);
        int unsigned rd0, wr0;
        int unsigned cyc;
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        va = v; is_write = wr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_err++;
            $display("FAIL R10: actual no done expected done within 2000 cycles");
        end
        r_pa = pa; r_fault = fault; r_wp = pa_wp; r_ci = pa_ci;
        d_rd = rd_cnt - rd0; d_wr = wr_cnt - wr0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R10 reset busy", 32'(busy), 32'd0);
        chk("R10 reset done", 32'(done), 32'd0);
        chk("R11 reset req", 32'(mem_req), 32'd0);
        chk("R6 reset fault", 32'(fault), 32'd0);
    endtask

    task automatic t_three_level_read();
        run_walk(mkva(5, 9, 17, 13'h123), 1'b0);
        chk("R6 pa", r_pa, 32'h00AB_C123);
        chk("R6 fault", 32'(r_fault), 32'd0);
        chk("R6 ci", 32'(r_ci), 32'd0);
        chk("R7 wp", 32'(r_wp), 32'd0);
        chk("R3 reads long+short", 32'(d_rd), 32'd4);
        chk("R8 writes", 32'(d_wr), 32'd3);
        chk("R8 l1 used", peek(32'h28), 32'h0000_000A);
        chk("R8 l2 used", peek(32'h1024), 32'h0000_200A);
        chk("R8 l3 used", peek(32'h2044), 32'h00AB_C009);
    endtask

    task automatic t_repeat_write_modified();
        run_walk(mkva(5, 9, 17, 13'h1FFF), 1'b1);
        chk("R9 pa", r_pa, 32'h00AB_DFFF);
        chk("R9 fault", 32'(r_fault), 32'd0);
        chk("R8 R9 single write", 32'(d_wr), 32'd1);
        chk("R9 modified set", peek(32'h2044), 32'h00AB_C019);
        chk("R8 l1 untouched", peek(32'h28), 32'h0000_000A);
    endtask

    task automatic t_l1_page_early();
        logic [31:0] v;
        v = mkva(20, 42, 21, 13'h1ABC);
        run_walk(v, 1'b0);
        chk("R5 l1 page pa", r_pa, 32'h7E00_0000 | (v & 32'h01FF_FFFF));
        chk("R5 l1 page ci", 32'(r_ci), 32'd1);
        chk("R5 l1 page reads", 32'(d_rd), 32'd2);
        chk("R8 l1 page used", peek(32'hA0), 32'h0000_0049);
    endtask

    task automatic t_l2_short_page();
        logic [31:0] v;
        v = mkva(5, 12, 7, 13'h0F0F);
        run_walk(v, 1'b0);
        chk("R5 l2 page pa", r_pa, 32'h1238_0000 | (v & 32'h0007_FFFF));
        chk("R5 l2 page fault", 32'(r_fault), 32'd0);
        chk("R5 l2 page reads", 32'(d_rd), 32'd3);
    endtask

    task automatic t_long_second_level();
        run_walk(mkva(30, 3, 17, 13'h0042), 1'b0);
        chk("R3 long l2 pa", r_pa, 32'h00AB_C042);
        chk("R3 long l2 reads", 32'(d_rd), 32'd5);
        chk("R4 long l2 writes", 32'(d_wr), 32'd2);
        chk("R3 long l2 attr at base+i*8", peek(32'h3018), 32'h0000_000A);
    endtask

    task automatic t_invalid_entries();
        run_walk(mkva(5, 40, 0, 0), 1'b0);
        chk("R4 type0 fault", 32'(r_fault), 32'd1);
        chk("R7 fault pa zero", r_pa, 32'd0);
        chk("R4 type0 no write", 32'(d_wr), 32'd0);
        run_walk(mkva(5, 41, 0, 0), 1'b0);
        chk("R4 l3 table type fault", 32'(r_fault), 32'd1);
        chk("R4 l3 table type writes", 32'(d_wr), 32'd1);
        chk("R4 l3 entry unchanged", peek(32'h2400), 32'h0000_0002);
    endtask

    task automatic t_write_protect();
        run_walk(mkva(5, 50, 1, 13'h0077), 1'b1);
        chk("R7 prot fault", 32'(r_fault), 32'd2);
        chk("R7 prot no write", 32'(d_wr), 32'd0);
        chk("R7 wp entry unchanged", peek(32'h10C8), 32'h0000_2806);
        chk("R7 l3 untouched", peek(32'h2804), 32'h00C0_0001);
        run_walk(mkva(5, 50, 1, 13'h0077), 1'b0);
        chk("R7 read fault", 32'(r_fault), 32'd0);
        chk("R7 read wp", 32'(r_wp), 32'd1);
        chk("R7 read pa", r_pa, 32'h00C0_0077);
        chk("R8 read writes", 32'(d_wr), 32'd2);
    endtask

    task automatic t_root_limit();
        root_attr = 32'h0003_0003;
        run_walk(mkva(5, 9, 17, 0), 1'b0);
        chk("R2 over limit fault", 32'(r_fault), 32'd3);
        chk("R2 over limit no access", 32'(d_rd + d_wr), 32'd0);
        run_walk(mkva(3, 0, 0, 0), 1'b0);
        chk("R2 at limit passes", 32'(r_fault), 32'd1);
        chk("R2 at limit reads", 32'(d_rd), 32'd1);
        root_attr = 32'h8003_0003;
        run_walk(mkva(5, 9, 17, 13'h0005), 1'b0);
        chk("R2 lower flag no test", r_pa, 32'h00AB_C005);
        root_attr = 32'h8000_0003;
    endtask

    task automatic t_root_invalid();
        root_attr = 32'h8000_0000;
        run_walk(mkva(5, 9, 17, 0), 1'b0);
        chk("R1 root type0", 32'(r_fault), 32'd1);
        chk("R1 root type0 no access", 32'(d_rd), 32'd0);
        root_attr = 32'h8000_0001;
        run_walk(mkva(5, 9, 17, 0), 1'b0);
        chk("R1 root type1", 32'(r_fault), 32'd1);
        root_attr = 32'h8000_0007;
        run_walk(mkva(5, 9, 17, 0), 1'b1);
        chk("R7 root wp write", 32'(r_fault), 32'd2);
        root_attr = 32'h8000_0003;
    endtask

    task automatic t_busy_ignore();
        int unsigned cyc;
        @(negedge clk);
        va = mkva(5, 9, 17, 13'h0321); is_write = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after start", 32'(busy), 32'd1);
        va = mkva(5, 40, 0, 0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R10 second start ignored", pa, 32'h00AB_C321);
        chk("R10 ignored fault", 32'(fault), 32'd0);
        @(negedge clk);
        chk("R10 done one cycle", 32'(done), 32'd0);
        chk("R10 idle after done", 32'(busy), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        poke(32'h28,   32'h0000_0002);
        poke(32'h2C,   32'h0000_1000);
        poke(32'h1024, 32'h0000_2002);
        poke(32'h2044, 32'h00AB_C001);
        poke(32'hA0,   32'h0000_0041);
        poke(32'hA4,   32'h7E00_0000);
        poke(32'h1030, 32'h1238_0001);
        poke(32'hF0,   32'h0000_0003);
        poke(32'hF4,   32'h0000_3000);
        poke(32'h3018, 32'h0000_0002);
        poke(32'h301C, 32'h0000_2000);
        poke(32'h10A4, 32'h0000_2402);
        poke(32'h2400, 32'h0000_0002);
        poke(32'h10C8, 32'h0000_2806);
        poke(32'h2804, 32'h00C0_0001);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_root_invalid();
        t_three_level_read();
        t_repeat_write_modified();
        t_l1_page_early();
        t_l2_short_page();
        t_long_second_level();
        t_invalid_entries();
        t_write_protect();
        t_root_limit();
        t_busy_ignore();
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule